// File: doc/BRIEF.md
# Multi-Sender Message Queue with Per-Sender Overflow Flags

This block is a hardware message queue that several processors share as a single inbox. Any processor may push a 32-bit word into it through a register write. The low six bits of every pushed word name the sender, and the upper 26 bits are the message. A single consumer takes words out, oldest first, through a register read. A level interrupt tells the consumer that words are waiting. It drops by itself when the queue is drained.

The full check and the store happen in the same cycle. A push that finds the queue full is thrown away, and a sticky flag is raised for the sender named in the word. Each sender can then read the flags and learn whether its own push landed. It clears its flag by writing a one to that bit. Popping an empty queue returns all ones and raises a separate sticky marker.

The bus is single-cycle. It has a write side and a read side, and each side has its own address, so a push and a pop can occur in the same cycle. Read data is combinational from the current state. A pop takes effect at the clock edge that ends the read cycle.

Top module: `ipc_msg_queue`

## Requirements
- R1: A write to offset 0x00 while the queue holds fewer than 128 entries stores the 32-bit word. Entries leave in the order they arrived.
- R2: A read of offset 0x04 while the queue is not empty returns the oldest entry, with bits [5:0] forced to zero. The entry is then removed at the clock edge.
- R3: A write to offset 0x00 while the queue holds 128 entries is discarded. The sender ID is bits [5:0] of the written word. For sender IDs 0 to 31 the push sets bit ID of offset 0x10. For sender IDs 32 to 62 it sets bit ID-32 of offset 0x14. Sender ID 63 records nothing.
- R4: Flags are sticky. Writing 1 to a bit of offset 0x10 or 0x14 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R5: A read of offset 0x04 while the queue is empty returns 0xFFFFFFFF. It leaves the queue contents and order unchanged, and it sets bit 31 of offset 0x14.
- R6: The interrupt output is high exactly while the queue holds at least one entry. It is low from the cycle after the last entry is popped.
- R7: A push and a pop in the same cycle are both accepted when the queue is neither empty nor full, and the entry count is unchanged. When the queue is full, the pop is served and the push is dropped as in R3. When the queue is empty, the pop returns all ones as in R5 and the push is stored.
- R8: While reset is asserted, the queue is emptied, all flags are cleared and the interrupt is low.
- R9: Reads of offset 0x00 and of any unmapped offset return zero. A read with the read enable low returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mq_wr_en | input | 1 | Write strobe |
| mq_wr_addr | input | 5 | Write byte offset |
| mq_wr_data | input | 32 | Write data (push word or clear mask) |
| mq_rd_en | input | 1 | Read strobe |
| mq_rd_addr | input | 5 | Read byte offset |
| mq_rd_data | output | 32 | Read data, valid in the cycle of the read |
| mq_irq | output | 1 | High while the queue is not empty |

## Verification
The checker assumes three things about the inputs:
- Each strobe stands for at most one access per cycle.
- Inputs carry known values once reset is released.
- A push and a flag-clear write cannot share a cycle, because there is one write port.

The bench changes inputs only on the falling edge and deasserts both strobes after every access, so no access is ever counted twice. It reaches the "set and clear in the same cycle" case only through the read side, by popping an empty queue while clearing the high flag register.

// File: rtl/ipc_mq_pkg.sv
package ipc_mq_pkg;

  localparam int DATA_W    = 32;
  localparam int ID_W      = 6;
  localparam int ADDR_W    = 5;
  localparam int BANK_W    = 32;
  localparam int NFLAG     = 2 ** ID_W;
  localparam int N_BANK    = NFLAG / BANK_W;
  localparam int EMPTY_BIT = NFLAG - 1;

  localparam logic [ADDR_W-1:0] OFS_PUSH = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_POP  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h10;

  localparam logic [ID_W-1:0] ID_RSVD = '1;

  // Byte offset of flag bank b (banks are consecutive 32-bit words).
  function automatic logic [ADDR_W-1:0] bank_ofs(int b);
    return OFS_FLAG + ADDR_W'(4 * b);
  endfunction

  function automatic logic [ID_W-1:0] sender_of(logic [DATA_W-1:0] w);
    return w[ID_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] strip_id(logic [DATA_W-1:0] w);
    return {w[DATA_W-1:ID_W], {ID_W{1'b0}}};
  endfunction

  // One-hot overflow flag for a sender; the reserved ID maps to nothing.
  function automatic logic [NFLAG-1:0] onehot_flag(logic [ID_W-1:0] id);
    logic [NFLAG-1:0] v;
    v = '0;
    if (id != ID_RSVD) v[id] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/ipc_mq_ring.sv
module ipc_mq_ring #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     rd_ptr;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign empty     = (level == '0);
  assign full      = (level == LW'(DEPTH));

endmodule

// File: rtl/ipc_mq_flags.sv
module ipc_mq_flags #(
  parameter int BANK_W = 32,
  parameter int N_BANK = 2,
  localparam int NF    = BANK_W * N_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF-1:0]     set_vec,
  input  logic [N_BANK-1:0] clr_bank,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [NF-1:0]     flags
);

  logic [NF-1:0] clr_vec;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign clr_vec[b*BANK_W +: BANK_W] = clr_bank[b] ? clr_mask : '0;
  end

  // Clear first, then set: a new event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/ipc_msg_queue.sv
module ipc_msg_queue
  import ipc_mq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mq_wr_en,
  input  logic [ADDR_W-1:0] mq_wr_addr,
  input  logic [DATA_W-1:0] mq_wr_data,
  input  logic              mq_rd_en,
  input  logic [ADDR_W-1:0] mq_rd_addr,
  output logic [DATA_W-1:0] mq_rd_data,
  output logic              mq_irq
);

  // Named internal events, brought out for the checker.
  logic              push_req, push_ok, push_drop;
  logic              pop_req, pop_ok, pop_empty;
  logic [ID_W-1:0]   drop_id;
  logic              empty, full;
  logic [LW-1:0]     level;
  logic [DATA_W-1:0] head_data;
  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  set_vec;
  logic [N_BANK-1:0] clr_bank;

  assign push_req  = mq_wr_en && (mq_wr_addr == OFS_PUSH);
  assign push_ok   = push_req && !full;
  assign push_drop = push_req && full;
  assign drop_id   = sender_of(mq_wr_data);

  assign pop_req   = mq_rd_en && (mq_rd_addr == OFS_POP);
  assign pop_ok    = pop_req && !empty;
  assign pop_empty = pop_req && empty;

  assign set_vec = (push_drop ? onehot_flag(drop_id) : '0)
                 | (pop_empty ? (NFLAG'(1) << EMPTY_BIT) : '0);

  for (genvar b = 0; b < N_BANK; b++) begin : g_clr
    assign clr_bank[b] = mq_wr_en && (mq_wr_addr == bank_ofs(b));
  end

  ipc_mq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ok),
    .push_data (mq_wr_data),
    .pop       (pop_ok),
    .head_data (head_data),
    .level     (level),
    .empty     (empty),
    .full      (full)
  );

  ipc_mq_flags #(.BANK_W(BANK_W), .N_BANK(N_BANK)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_bank (clr_bank),
    .clr_mask (mq_wr_data),
    .flags    (flags)
  );

  always_comb begin
    mq_rd_data = '0;
    if (mq_rd_en) begin
      if (mq_rd_addr == OFS_POP) begin
        mq_rd_data = empty ? '1 : strip_id(head_data);
      end
      for (int b = 0; b < N_BANK; b++) begin
        if (mq_rd_addr == bank_ofs(b)) mq_rd_data = flags[b*BANK_W +: BANK_W];
      end
    end
  end

  assign mq_irq = !empty;

endmodule

// File: rtl/ipc_mq_chk.sv
module ipc_mq_chk
  import ipc_mq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_ok,
  input logic              push_drop,
  input logic              pop_ok,
  input logic              pop_empty,
  input logic [ID_W-1:0]   drop_id,
  input logic [LW-1:0]     level,
  input logic [NFLAG-1:0]  flags,
  input logic              mq_irq,
  input logic [DATA_W-1:0] mq_rd_data
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> level < LW'(DEPTH)); // R1
  AST_POP_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> mq_rd_data[ID_W-1:0] == '0); // R2
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |-> level == LW'(DEPTH)); // R3
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && drop_id != ID_RSVD) |=> flags[$past(drop_id)]); // R3
  AST_EMPTY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |-> mq_rd_data == '1); // R5
  AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> flags[EMPTY_BIT]); // R5
  AST_PUSH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> mq_irq); // R6
  AST_PAIR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(level)); // R7

endmodule

bind ipc_msg_queue ipc_mq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_ok    (push_ok),
  .push_drop  (push_drop),
  .pop_ok     (pop_ok),
  .pop_empty  (pop_empty),
  .drop_id    (drop_id),
  .level      (level),
  .flags      (flags),
  .mq_irq     (mq_irq),
  .mq_rd_data (mq_rd_data)
);

// File: tb/tb_ipc_msg_queue.sv
`timescale 1ns/1ps
module tb_ipc_msg_queue;

  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mq_wr_en = 1'b0;
  logic [4:0]  mq_wr_addr = '0;
  logic [31:0] mq_wr_data = '0;
  logic        mq_rd_en = 1'b0;
  logic [4:0]  mq_rd_addr = '0;
  logic [31:0] mq_rd_data;
  logic        mq_irq;

  ipc_msg_queue #(.DEPTH(DEPTH)) dut (.*);

  always #2.5 clk = ~clk;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] mq[$];
  logic [63:0] mflags = '0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle with an optional push and an optional pop; the model uses the pre-state.
  task automatic xfer(bit dp, logic [31:0] wd, bit dq, string tag);
    logic [31:0] exp;
    int pre;
    pre = mq.size();
    @(negedge clk);
    mq_wr_en = dp; mq_wr_addr = 5'h00; mq_wr_data = wd;
    mq_rd_en = dq; mq_rd_addr = 5'h04;
    #1;
    if (dq) begin
      exp = (pre == 0) ? 32'hFFFF_FFFF : (mq[0] & ~32'h3F);
      chk(mq_rd_data === exp, tag, mq_rd_data, exp);
      if (pre > 0) void'(mq.pop_front());
      else mflags[63] = 1'b1;
    end
    if (dp) begin
      if (pre < DEPTH) mq.push_back(wd);
      else if (wd[5:0] != 6'h3F) mflags[wd[5:0]] = 1'b1;
    end
    @(posedge clk); #1;
    mq_wr_en = 1'b0; mq_rd_en = 1'b0;
  endtask

  task automatic wreg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    mq_wr_en = 1'b1; mq_wr_addr = a; mq_wr_data = d;
    if (a == 5'h10) mflags[31:0]  = mflags[31:0]  & ~d;
    if (a == 5'h14) mflags[63:32] = mflags[63:32] & ~d;
    @(posedge clk); #1;
    mq_wr_en = 1'b0;
  endtask

  task automatic rreg(logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    mq_rd_en = 1'b1; mq_rd_addr = a;
    #1 v = mq_rd_data;
    @(posedge clk); #1;
    mq_rd_en = 1'b0;
  endtask

  task automatic check_flags(string tag);
    logic [31:0] v;
    rreg(5'h10, v); chk(v === mflags[31:0],  {tag, " flags@0x10"}, v, mflags[31:0]);
    rreg(5'h14, v); chk(v === mflags[63:32], {tag, " flags@0x14"}, v, mflags[63:32]);
  endtask

  task automatic check_irq(string tag);
    @(negedge clk); #1;
    chk(mq_irq === (mq.size() != 0), {tag, " irq"}, 32'(mq_irq), 32'(mq.size() != 0));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("[TB] watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: reset state
    check_irq("R8");
    check_flags("R8");

    // R9: unmapped and push offsets read zero; idle read data is zero
    rreg(5'h08, v); chk(v === 32'h0, "R9 unmapped read", v, 32'h0);
    rreg(5'h00, v); chk(v === 32'h0, "R9 push-offset read", v, 32'h0);
    @(negedge clk); #1 chk(mq_rd_data === 32'h0, "R9 idle read", mq_rd_data, 32'h0);

    // R1: fill to capacity with varied payloads and IDs
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b1, {26'(i * 37 + 5), 6'(i % 63)}, 1'b0, "R1");
      if (i == 0) check_irq("R6 first push");
    end
    check_irq("R6 full");
    check_flags("R1 no drop below capacity");

    // R3: every sender pushes into the full queue
    for (int id = 0; id < 64; id++) xfer(1'b1, {26'(id * 3 + 1), 6'(id)}, 1'b0, "R3");
    rreg(5'h10, v); chk(v === 32'hFFFF_FFFF, "R3 low flags", v, 32'hFFFF_FFFF);
    rreg(5'h14, v); chk(v === 32'h7FFF_FFFF, "R3 high flags, id 63 ignored", v, 32'h7FFF_FFFF);

    // R4: write-one-to-clear, zeros leave flags alone
    wreg(5'h10, 32'h0000_FFFF); check_flags("R4 partial clear");
    wreg(5'h14, 32'h0000_0000); check_flags("R4 zero write");
    wreg(5'h10, 32'hFFFF_FFFF);
    wreg(5'h14, 32'hFFFF_FFFF); check_flags("R4 full clear");

    // R7: full queue, push and pop together -> push dropped, pop served
    xfer(1'b1, 32'hABCD_E045, 1'b1, "R7 full pair");
    check_flags("R7 full pair drop");
    for (int k = 0; k < 20; k++) xfer(1'b1, {26'(k * 911 + 7), 6'(k)}, 1'b1, "R7 pair");
    check_irq("R7");

    // R2: drain, checking order and the cleared sender field
    while (mq.size() > 1) xfer(1'b0, 32'h0, 1'b1, "R2");
    check_irq("R6 one left");
    xfer(1'b0, 32'h0, 1'b1, "R2 last");
    check_irq("R6 drained");

    // R5: empty pop returns ones, marks, and leaves pointers alone
    xfer(1'b0, 32'h0, 1'b1, "R5 empty pop");
    check_flags("R5 empty marker");
    check_irq("R5");
    xfer(1'b1, 32'h1234_5681, 1'b0, "R5");
    xfer(1'b0, 32'h0, 1'b1, "R5 order after empty pop");

    // R4: set wins over a same-cycle clear
    @(negedge clk);
    mq_rd_en = 1'b1; mq_rd_addr = 5'h04;
    mq_wr_en = 1'b1; mq_wr_addr = 5'h14; mq_wr_data = 32'h8000_0000;
    @(posedge clk); #1;
    mq_rd_en = 1'b0; mq_wr_en = 1'b0;
    mflags[63] = 1'b1;
    check_flags("R4 set beats clear");
    wreg(5'h14, 32'hFFFF_FFFF);
    wreg(5'h10, 32'hFFFF_FFFF);

    // R7: empty queue, push and pop together
    xfer(1'b1, 32'hCAFE_0002, 1'b1, "R7 empty pair");
    check_irq("R7 empty pair");
    check_flags("R7 empty pair marker");
    xfer(1'b0, 32'h0, 1'b1, "R7 empty pair data");

    // R8: reset in the middle of traffic
    for (int j = 0; j < 3; j++) xfer(1'b1, {26'(j + 100), 6'd40}, 1'b0, "R8 prefill");
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    mflags = '0;
    check_irq("R8 mid reset");
    check_flags("R8 mid reset");
    xfer(1'b0, 32'h0, 1'b1, "R8 empty after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule